// File: doc/BRIEF.md
# Best-Quality Selector Tree

This block looks at an array of candidate words that arrive together and returns the one whose quality key is highest. The key is the low-order slice of each word, `KEY_W` bits wide, read as an unsigned number. Besides the winning word, the block returns the position of the winner in the array. When several candidates share the top key, the one at the lowest position wins. A key width of 1 with a valid flag in bit 0 turns the block into a first-valid picker.

The selection runs through a balanced binary reduction tree of compare-and-select nodes, so the tree has ceil(log2 N_IN) levels. A count that is not a power of two is padded up with zero-key entries at the top positions. Three parameters control timing: one adds a register on the input side, one adds a register on the output side, and one adds a pipeline cut after every `CUT_EVERY`-th tree level. A valid bit travels alongside the data with the same delay but plays no part in the choice. A new set of candidates can be presented every cycle.

Top module: `best_qual_select`

## Requirements
- R1: The winner is the candidate whose bits [KEY_W-1:0] form the largest unsigned value. `out_word` is the full word of that candidate and `out_idx` is its position, where candidate i occupies `in_words[i*WORD_W +: WORD_W]`.
- R2: When several candidates share the highest key, the one with the lowest position is chosen.
- R3: `out_idx` is ceil(log2 N_IN) bits wide. Padding positions from N_IN up to the next power of two hold zero-key entries and are never reported, so `out_idx` is always below N_IN. When every key is zero, `out_idx` is 0 and `out_word` equals candidate 0.
- R4: The latency from inputs to outputs is IN_REG + OUT_REG + floor((D-1)/CUT_EVERY) cycles, with D = ceil(log2 N_IN) and no cuts when CUT_EVERY is 0. A cut sits after tree level l (counting from 1) when l is a multiple of CUT_EVERY and l < D. For N_IN=6, IN_REG=1, OUT_REG=1 and CUT_EVERY=2, the latency is 3 cycles.
- R5: `out_vld` equals `in_vld` delayed by the R4 latency. `in_vld` has no effect on `out_word` or `out_idx`.
- R6: When `rst_n` is sampled low at a rising clock edge, every register is cleared. With the input and output registers enabled, `out_vld`, `out_word` and `out_idx` read 0 after that edge.
- R7: Bits above the key pass through unchanged in `out_word` and never influence which candidate wins.
- R8: The block accepts a new candidate set every cycle and produces one result per cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Valid flag travelling alongside the candidates |
| in_words | input | N_IN*WORD_W | Packed candidate words, candidate i at bits [i*WORD_W +: WORD_W] |
| out_vld | output | 1 | Valid flag delayed by the pipeline latency |
| out_word | output | WORD_W | Full word of the winning candidate |
| out_idx | output | ceil(log2 N_IN) | Position of the winning candidate |

## Verification
A compare node that keeps the wrong side on a tie, or that reads the wrong key slice, shows up as a wrong `out_idx` or `out_word` exactly one latency after the stimulus that exposes it. An exhaustive sweep over every key combination of six candidates makes sure each node meets every tie and ordering it can see. A misplaced pipeline cut or a wrong valid delay shifts every result by whole cycles. That shift is caught in the first cycle of the stream, because each cycle carries different random upper bits and valid values. A padding entry that leaks through appears as an index of 6 or 7 as soon as all real keys are zero.

// File: rtl/bqs_pkg.sv
// Package: bqs_pkg
// Elaboration-time helpers shared by the selector tree. They give the level
// offsets inside the flat slot vectors, the placement of the pipeline cuts
// and the total latency.
// Assumes: np is a power of two, depth >= 1.
package bqs_pkg;

    // True when a pipeline cut follows tree level lv (0-based).
    function automatic bit bqs_cut_after(int lv, int depth, int period);
        return (period > 0) && ((lv + 1) < depth) && (((lv + 1) % period) == 0);
    endfunction

    // Slot offset of the input side of level lv in the packed input-slot vector.
    function automatic int bqs_in_off(int np, int lv);
        return 2 * np - 2 * (np >> lv);
    endfunction

    // Slot offset of the output side of level lv in the packed node-output vector.
    function automatic int bqs_out_off(int np, int lv);
        return np - 2 * (np >> (lv + 1));
    endfunction

    // Total cycles from the inputs to the outputs.
    function automatic int bqs_latency(int depth, bit in_reg, bit out_reg, int period);
        int n;
        n = int'(in_reg) + int'(out_reg);
        if (period > 0)
            n = n + (depth - 1) / period;
        return n;
    endfunction

endpackage

// File: rtl/bqs_node.sv
// Module: bqs_node
// One compare-and-select node of the reduction tree. It keeps the candidate
// with the larger low-order key. On equal keys it keeps side a, which always
// carries the lower position.
// Assumes: the caller wires the lower-position candidate to side a.
module bqs_node #(
    parameter int WORD_W = 8,
    parameter int KEY_W  = 3,
    parameter int IDX_W  = 3
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [WORD_W-1:0] b_word,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [WORD_W-1:0] win_word,
    output logic [IDX_W-1:0]  win_idx
);

    logic [KEY_W-1:0] a_key;
    logic [KEY_W-1:0] b_key;
    logic             take_b;

    // Pick side b only on a strictly larger key.
    always_comb begin
        a_key    = a_word[KEY_W-1:0];
        b_key    = b_word[KEY_W-1:0];
        take_b   = (b_key > a_key);
        win_word = take_b ? b_word : a_word;
        win_idx  = take_b ? b_idx  : a_idx;
    end

    // Node-level checks on the chosen key and the tie rule.
    always_comb begin
        if (!$isunknown({a_word, a_idx, b_word, b_idx})) begin
            p_best_key_r1: assert ((win_word[KEY_W-1:0] >= a_word[KEY_W-1:0]) &&
                                   (win_word[KEY_W-1:0] >= b_word[KEY_W-1:0]))
                else $error("node kept a smaller key");
            p_tie_left_r2: assert ((a_word[KEY_W-1:0] != b_word[KEY_W-1:0]) || (win_idx == a_idx))
                else $error("node broke a tie toward the higher position");
        end
    end

endmodule

// File: rtl/bqs_pipe_reg.sv
// Module: bqs_pipe_reg
// Optional register stage of width W. With EN set, it is a flop bank that
// clears on synchronous active-low reset. With EN clear, it is a plain wire.
// Assumes: nothing beyond a single clock domain.
module bqs_pipe_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (EN) begin : g_reg
        // Capture the stage input each cycle, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else
                q <= d;
        end
    end else begin : g_wire
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign q = d;
    end

endmodule

// File: rtl/bqs_vld_delay.sv
// Module: bqs_vld_delay
// Delays the valid flag by DEPTH cycles so that it lines up with the
// selected data. With DEPTH of 0 it is a wire.
// Assumes: DEPTH equals the data path latency computed in bqs_pkg.
module bqs_vld_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    output logic vld_out
);

    if (DEPTH == 0) begin : g_none
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign vld_out = vld_in;
    end else begin : g_chain
        logic [DEPTH-1:0] sr;

        // Shift the flag one place per cycle, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr <= '0;
            end else begin
                sr[0] <= vld_in;
                for (int k = 1; k < DEPTH; k++)
                    sr[k] <= sr[k-1];
            end
        end
        assign vld_out = sr[DEPTH-1];

        if (DEPTH <= 8) begin : g_chk
            logic [7:0] since_rst;

            // Count cycles since reset, saturating at DEPTH, to gate the check.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    since_rst <= '0;
                else if (since_rst < 8'(DEPTH))
                    since_rst <= since_rst + 8'd1;
            end

            p_vld_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 8'(DEPTH)) |-> (vld_out == $past(vld_in, DEPTH)))
                else $error("valid flag latency mismatch");
        end
    end

endmodule

// File: rtl/best_qual_select.sv
// Module: best_qual_select
// Picks the candidate with the largest low-order key among N_IN words. Ties
// go to the lowest position. The module returns the winner's word and
// position. A binary tree of bqs_node instances reduces the set level by
// level. Optional registers sit on the input side, after every CUT_EVERY-th
// level, and on the output side. A valid flag follows with the same delay.
// Assumes: N_IN >= 2 and KEY_W <= WORD_W. Counts that are not a power of two
// are padded with zero-key entries at the top positions.
module best_qual_select
    import bqs_pkg::*;
#(
    parameter int N_IN      = 8,
    parameter int WORD_W    = 8,
    parameter int KEY_W     = 3,
    parameter bit IN_REG    = 1'b1,
    parameter bit OUT_REG   = 1'b1,
    parameter int CUT_EVERY = 2,
    localparam int IDX_W    = $clog2(N_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [N_IN*WORD_W-1:0]   in_words,
    output logic                     out_vld,
    output logic [WORD_W-1:0]        out_word,
    output logic [IDX_W-1:0]         out_idx
);

    localparam int DEPTH = $clog2(N_IN);
    localparam int NP    = 1 << DEPTH;
    localparam int CW    = WORD_W + IDX_W;
    localparam int LAT   = bqs_latency(DEPTH, IN_REG, OUT_REG, CUT_EVERY);

    // Slot layout: each slot is {index, word}. The input-side slots of all
    // levels (NP + NP/2 + ... + 1) sit in one vector, the node outputs in another.
    logic [NP*CW-1:0]       raw_vec;
    logic [(2*NP-1)*CW-1:0] tree_in;
    logic [(NP-1)*CW-1:0]   tree_out;
    logic [CW-1:0]          out_cand;

    // Build the padded candidate array with each slot tagged by its position.
    for (genvar j = 0; j < NP; j++) begin : g_slot
        if (j < N_IN) begin : g_real
            assign raw_vec[j*CW +: CW] = {IDX_W'(j), in_words[j*WORD_W +: WORD_W]};
        end else begin : g_pad
            assign raw_vec[j*CW +: CW] = {IDX_W'(j), {WORD_W{1'b0}}};
        end
    end

    bqs_pipe_reg #(.W(NP*CW), .EN(IN_REG)) u_in_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (tree_in[NP*CW-1:0])
    );

    // Reduction levels: halve the candidates, then an optional cut.
    for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
        localparam int CNT  = NP >> (lv + 1);
        localparam int IOFF = bqs_in_off(NP, lv);
        localparam int OOFF = bqs_out_off(NP, lv);
        localparam int NOFF = bqs_in_off(NP, lv + 1);

        for (genvar j = 0; j < CNT; j++) begin : g_node
            localparam int SA = (IOFF + 2*j) * CW;
            localparam int SB = (IOFF + 2*j + 1) * CW;
            localparam int SO = (OOFF + j) * CW;

            bqs_node #(.WORD_W(WORD_W), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_node (
                .a_word   (tree_in[SA +: WORD_W]),
                .a_idx    (tree_in[SA + WORD_W +: IDX_W]),
                .b_word   (tree_in[SB +: WORD_W]),
                .b_idx    (tree_in[SB + WORD_W +: IDX_W]),
                .win_word (tree_out[SO +: WORD_W]),
                .win_idx  (tree_out[SO + WORD_W +: IDX_W])
            );
        end

        bqs_pipe_reg #(.W(CNT*CW), .EN(bqs_cut_after(lv, DEPTH, CUT_EVERY))) u_cut (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (tree_out[OOFF*CW +: CNT*CW]),
            .q     (tree_in[NOFF*CW +: CNT*CW])
        );
    end

    bqs_pipe_reg #(.W(CW), .EN(OUT_REG)) u_out_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tree_in[(2*NP-2)*CW +: CW]),
        .q     (out_cand)
    );

    // Split the final slot into the word and position outputs.
    always_comb begin
        out_word = out_cand[WORD_W-1:0];
        out_idx  = out_cand[CW-1:WORD_W];
    end

    bqs_vld_delay #(.DEPTH(LAT)) u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_vld),
        .vld_out (out_vld)
    );

    p_pad_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(out_idx) < N_IN))
        else $error("padding position reached the output");

endmodule

// File: tb/sim_best_qual_select.sv
`timescale 1ns/1ps
module sim_best_qual_select;

    localparam int N   = 6;
    localparam int W   = 6;
    localparam int K   = 2;
    localparam int IW  = 3;
    localparam int LAT = 3;   // R4: 1 + 1 + floor((3-1)/2)

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_vld;
    logic [N*W-1:0]  in_words;
    logic            out_vld;
    logic [W-1:0]    out_word;
    logic [IW-1:0]   out_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int filled  = 0;
    bit done    = 1'b0;

    logic [W-1:0]  e_word [4];
    logic [IW-1:0] e_idx  [4];
    logic          e_vld  [4];
    string         e_tag  [4];

    always #2 clk = ~clk;

    best_qual_select #(
        .N_IN(N), .WORD_W(W), .KEY_W(K),
        .IN_REG(1'b1), .OUT_REG(1'b1), .CUT_EVERY(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_words(in_words),
        .out_vld(out_vld), .out_word(out_word), .out_idx(out_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference: largest key wins, first position on ties.
    task automatic ref_pick(input logic [N*W-1:0] ws, output logic [W-1:0] bw,
                            output logic [IW-1:0] bi, output string tag);
        int best = -1;
        int ties = 0;
        for (int i = 0; i < N; i++) begin
            int key = int'(ws[i*W +: K]);
            if (key > best) begin
                best = key;
                bi   = IW'(i);
                bw   = ws[i*W +: W];
            end
        end
        for (int i = 0; i < N; i++)
            if (int'(ws[i*W +: K]) == best) ties++;
        if (best == 0)      tag = "R3 R2";
        else if (ties > 1)  tag = "R2 R4 R8";
        else                tag = "R1 R4 R8";
    endtask

    // Check the result due now, then drive one new candidate set.
    task automatic step(input logic [N*W-1:0] ws, input logic v);
        int s;
        if (filled >= LAT) begin
            s = (cyc - LAT) % 4;
            chk(out_idx == e_idx[s], e_tag[s], "out_idx", out_idx, e_idx[s]);
            chk(out_word == e_word[s], "R1 R7", "out_word", out_word, e_word[s]);
            chk(out_vld == e_vld[s], "R5", "out_vld", out_vld, e_vld[s]);
        end
        in_words = ws;
        in_vld   = v;
        s = cyc % 4;
        ref_pick(ws, e_word[s], e_idx[s], e_tag[s]);
        e_vld[s] = v;
        cyc++;
        filled++;
        @(negedge clk);
    endtask

    task automatic chk_zero(input string what);
        chk(out_vld == 1'b0, "R6", {what, " out_vld"}, out_vld, 0);
        chk(out_word == '0, "R6", {what, " out_word"}, out_word, 0);
        chk(out_idx == '0, "R6", {what, " out_idx"}, out_idx, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] ws;
        rst_n    = 1'b0;
        in_vld   = 1'b0;
        in_words = '0;
        repeat (3) @(negedge clk);
        chk_zero("initial reset");  // R6
        rst_n  = 1'b1;
        filled = 0;

        // R1 R2 R3 R5 R7 R8: every key combination, random upper bits and valid.
        for (int p = 0; p < 4096; p++) begin
            for (int i = 0; i < N; i++) begin
                logic [3:0] up;
                up = 4'($urandom_range(0, 15));
                ws[i*W +: W] = {up, 2'((p >> (2*i)) & 3)};
            end
            step(ws, 1'($urandom_range(0, 1)));
        end

        // R7: large upper bits on a low key must not win.
        ws = '0;
        ws[0*W +: W] = 6'b111100;
        ws[5*W +: W] = 6'b000001;
        for (int i = 1; i < 5; i++) ws[i*W +: W] = 6'b110000;
        step(ws, 1'b1);
        ws[2*W +: W] = 6'b111110;
        ws[3*W +: W] = 6'b000011;
        step(ws, 1'b0);
        // R3: all keys zero, random upper bits, the first position expected.
        for (int i = 0; i < N; i++) ws[i*W +: W] = {4'($urandom_range(1, 15)), 2'b00};
        step(ws, 1'b1);
        for (int f = 0; f < LAT; f++) step('0, 1'b0);

        // R6: reset in the middle of a stream clears every stage.
        ws = {N{6'b101011}};
        step(ws, 1'b1);
        step(ws, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_zero("mid-stream reset");
        rst_n  = 1'b1;
        filled = 0;
        ws[4*W +: W] = 6'b000011;
        step(ws, 1'b1);
        for (int f = 0; f < LAT; f++) step('0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule